// File: doc/BRIEF.md
# Burst-of-Four Separate-I/O SRAM Controller

This block connects a user request interface to a synchronous SRAM that has separate data-in and data-out buses, moves a fixed burst of four words per access, and transfers data on both clock edges. The user side has two independent request channels. The read channel takes a burst address. The write channel takes a burst address, four data words and per-beat byte enables. Both use a valid/ready handshake. On the device side the block drives a read select, a write select, a shared address bus, byte-enable strobes and write data. It captures the four read beats the device returns and presents them on a response port with a valid flag.

The design runs on a system clock at twice the device clock rate. Each system tick stands for one half of a device cycle. The output `dev_k_o` is high in ticks aligned with the device's main rising edge and low in ticks aligned with the inverted-clock edge. Commands may only appear on main-edge ticks, and reads and writes take turns on the single address bus. Each port can start a new burst at most once every two device cycles. Write beats start one device cycle after the write command, and read beats return five ticks after the read command.

Top module: `qb_burst_ctrl`

## Requirements
- R1: While reset is held, and in the first tick after it is released, `dev_rd_o`, `dev_wr_o` and `rsp_valid_o` are low and `dev_be_o` is zero. `rd_ready_o` and `wr_ready_o` are only ever high in ticks where `dev_k_o` is low.
- R2: `dev_rd_o` and `dev_wr_o` are high only in ticks where `dev_k_o` is high, and never both in the same tick.
- R3: A read accepted in tick n (`rd_valid_i` and `rd_ready_o` both high) drives `dev_rd_o` high in tick n+1 with `dev_addr_o` equal to the accepted address. `dev_rd_o` is low in every tick where no accepted read calls for it.
- R4: A write accepted in tick n drives `dev_wr_o` high in tick n+1 with `dev_addr_o` equal to the accepted address. `dev_wr_o` is low in every tick where no accepted write calls for it.
- R5: After a port accepts a request in tick n, its ready is low in tick n+2, so the same port accepts again no earlier than tick n+4.
- R6: When both ports are valid and neither is blocked by R5, the port that was not serviced last is granted. Directly after reset the read port counts as the one not serviced last.
- R7: For a write accepted in tick n, beat k (k = 0..3, taken from `wr_data_i[k*DATA_W +: DATA_W]` and `wr_be_i[k*BYTES +: BYTES]`) appears on `dev_d_o` and `dev_be_o` in tick n+3+k. Writes accepted four ticks apart produce gap-free beats. `dev_be_o` is zero in every tick that carries no write beat. Bit j of an enable covers data bits `[j*DATA_W/BYTES +: DATA_W/BYTES]`.
- R8: For a read accepted in tick n, the value on `dev_q_i` in tick n+6+k is presented on `rsp_data_o` in tick n+7+k, for k = 0..3. `rsp_valid_o` is high in exactly those ticks for each read.
- R9: The two ports operate concurrently. A write may be accepted and send its beats while an earlier read's beats are still being returned, and neither stream is disturbed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Double-rate system clock; one tick per device half-cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_valid_i | input | 1 | Read request valid |
| rd_ready_o | output | 1 | Read request accepted when high together with valid |
| rd_addr_i | input | ADDR_W | Read burst address |
| wr_valid_i | input | 1 | Write request valid |
| wr_ready_o | output | 1 | Write request accepted when high together with valid |
| wr_addr_i | input | ADDR_W | Write burst address |
| wr_data_i | input | 4*DATA_W | Four write beats, beat 0 in the low bits |
| wr_be_i | input | 4*BYTES | Byte enables per beat, beat 0 in the low bits |
| rsp_valid_o | output | 1 | Read response beat valid |
| rsp_data_o | output | DATA_W | Read response beat |
| dev_k_o | output | 1 | High in ticks aligned with the device main rising edge |
| dev_rd_o | output | 1 | Device read select (active high) |
| dev_wr_o | output | 1 | Device write select (active high) |
| dev_addr_o | output | ADDR_W | Device shared address bus |
| dev_be_o | output | BYTES | Device byte-write enables for the current beat |
| dev_d_o | output | DATA_W | Device write data for the current beat |
| dev_q_i | input | DATA_W | Device read data for the current tick |

## Verification
Different internal faults show up at different times. A phase bit that is out of step shows up as a command in a tick where `dev_k_o` is low, one tick after the first accept. A hold bit or a last-grant bit holding the wrong value changes which ready is raised at the next decision tick, so the wrong port is granted or one port is accepted twice within four ticks. A shift register that is off by one position shifts write beats or the response window by one tick, and this breaks the beat-to-tick match three to ten ticks after the accept. Corrupted beat order or masks show up later as read data that differs from the expected memory contents, on the first read of an address that was written.

// File: rtl/qb_pkg.sv
package qb_pkg;
    localparam int QB_BURST = 4;

    typedef enum logic [1:0] {
        QB_OP_NONE = 2'd0,
        QB_OP_RD   = 2'd1,
        QB_OP_WR   = 2'd2
    } qb_op_e;
endpackage

// File: rtl/qb_slot_arb.sv
// Decides, once per device cycle, which port drives the shared address slot.
module qb_slot_arb (
    input  logic clk,
    input  logic rst_n,
    input  logic slot_i,
    input  logic rd_valid_i,
    input  logic wr_valid_i,
    output logic rd_ready_o,
    output logic wr_ready_o,
    output logic rd_acc_o,
    output logic wr_acc_o
);
    typedef struct packed {
        logic rd_hold;
        logic wr_hold;
        logic last_wr;
    } arb_st_t;

    arb_st_t st_q, st_d;
    logic rd_want, wr_want;

    always_comb begin
        st_d    = st_q;
        rd_want = rd_valid_i && !st_q.rd_hold;
        wr_want = wr_valid_i && !st_q.wr_hold;
        // a port yields only when the other one competes and has the turn
        rd_ready_o = slot_i && !st_q.rd_hold && !(wr_want && !st_q.last_wr);
        wr_ready_o = slot_i && !st_q.wr_hold && !(rd_want && st_q.last_wr);
        rd_acc_o   = rd_valid_i && rd_ready_o;
        wr_acc_o   = wr_valid_i && wr_ready_o;
        if (slot_i) begin
            // a burst occupies its port for two device cycles
            st_d.rd_hold = rd_acc_o;
            st_d.wr_hold = wr_acc_o;
            if (rd_acc_o) st_d.last_wr = 1'b0;
            if (wr_acc_o) st_d.last_wr = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{rd_hold: 1'b0, wr_hold: 1'b0, last_wr: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/qb_wr_pipe.sv
// Tick-indexed staging line: each slot holds the beat due a fixed number of ticks ahead.
module qb_wr_pipe
    import qb_pkg::*;
#(
    parameter int DATA_W       = 18,
    parameter int BYTES        = 2,
    parameter int WR_LAG_TICKS = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       load_i,
    input  logic [QB_BURST*DATA_W-1:0] data_i,
    input  logic [QB_BURST*BYTES-1:0]  be_i,
    output logic [DATA_W-1:0]          dev_d_o,
    output logic [BYTES-1:0]           dev_be_o
);
    localparam int LEAD  = WR_LAG_TICKS - 1;
    localparam int DEPTH = LEAD + QB_BURST;

    typedef struct packed {
        logic [DEPTH-1:0][DATA_W-1:0] d;
        logic [DEPTH-1:0][BYTES-1:0]  be;
        logic [DATA_W-1:0]            od;
        logic [BYTES-1:0]             obe;
    } wp_st_t;

    wp_st_t st_q, st_d;

    always_comb begin
        st_d     = st_q;
        st_d.od  = st_q.d[0];
        st_d.obe = st_q.be[0];
        for (int i = 0; i < DEPTH - 1; i++) begin
            st_d.d[i]  = st_q.d[i+1];
            st_d.be[i] = st_q.be[i+1];
        end
        st_d.d[DEPTH-1]  = '0;
        st_d.be[DEPTH-1] = '0;
        if (load_i) begin
            for (int k = 0; k < QB_BURST; k++) begin
                st_d.d[k+LEAD]  = data_i[k*DATA_W +: DATA_W];
                st_d.be[k+LEAD] = be_i[k*BYTES +: BYTES];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dev_d_o  = st_q.od;
    assign dev_be_o = st_q.obe;
endmodule

// File: rtl/qb_rd_ret.sv
// Delay line of issued reads; opens a four-tick capture window at the fixed latency.
module qb_rd_ret
    import qb_pkg::*;
#(
    parameter int DATA_W       = 18,
    parameter int RD_LAT_TICKS = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue_i,
    input  logic [DATA_W-1:0] dev_q_i,
    output logic              rsp_valid_o,
    output logic [DATA_W-1:0] rsp_data_o
);
    localparam int LINE_W = RD_LAT_TICKS + QB_BURST - 1;

    typedef struct packed {
        logic [LINE_W-1:0] line;
        logic              vld;
        logic [DATA_W-1:0] data;
    } rr_st_t;

    rr_st_t st_q, st_d;
    logic   window;

    always_comb begin
        st_d      = st_q;
        window    = |st_q.line[RD_LAT_TICKS-1 +: QB_BURST];
        st_d.line = {st_q.line[LINE_W-2:0], issue_i};
        st_d.vld  = window;
        st_d.data = window ? dev_q_i : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rsp_valid_o = st_q.vld;
    assign rsp_data_o  = st_q.data;
endmodule

// File: rtl/qb_burst_ctrl.sv
module qb_burst_ctrl
    import qb_pkg::*;
#(
    parameter int DATA_W       = 18,
    parameter int BYTES        = 2,
    parameter int ADDR_W       = 8,
    parameter int RD_LAT_TICKS = 5,
    parameter int WR_LAG_TICKS = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       rd_valid_i,
    output logic                       rd_ready_o,
    input  logic [ADDR_W-1:0]          rd_addr_i,
    input  logic                       wr_valid_i,
    output logic                       wr_ready_o,
    input  logic [ADDR_W-1:0]          wr_addr_i,
    input  logic [QB_BURST*DATA_W-1:0] wr_data_i,
    input  logic [QB_BURST*BYTES-1:0]  wr_be_i,
    output logic                       rsp_valid_o,
    output logic [DATA_W-1:0]          rsp_data_o,
    output logic                       dev_k_o,
    output logic                       dev_rd_o,
    output logic                       dev_wr_o,
    output logic [ADDR_W-1:0]          dev_addr_o,
    output logic [BYTES-1:0]           dev_be_o,
    output logic [DATA_W-1:0]          dev_d_o,
    input  logic [DATA_W-1:0]          dev_q_i
);
    typedef struct packed {
        logic              ph;
        qb_op_e            cmd;
        logic [ADDR_W-1:0] addr;
    } top_st_t;

    top_st_t st_q, st_d;
    logic    rd_acc, wr_acc;

    qb_slot_arb arb_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .slot_i     (st_q.ph),
        .rd_valid_i (rd_valid_i),
        .wr_valid_i (wr_valid_i),
        .rd_ready_o (rd_ready_o),
        .wr_ready_o (wr_ready_o),
        .rd_acc_o   (rd_acc),
        .wr_acc_o   (wr_acc)
    );

    always_comb begin
        st_d     = st_q;
        st_d.ph  = ~st_q.ph;
        st_d.cmd = QB_OP_NONE;
        if (rd_acc) begin
            st_d.cmd  = QB_OP_RD;
            st_d.addr = rd_addr_i;
        end else if (wr_acc) begin
            st_d.cmd  = QB_OP_WR;
            st_d.addr = wr_addr_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{ph: 1'b0, cmd: QB_OP_NONE, addr: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign dev_k_o    = ~st_q.ph;
    assign dev_rd_o   = (st_q.cmd == QB_OP_RD);
    assign dev_wr_o   = (st_q.cmd == QB_OP_WR);
    assign dev_addr_o = st_q.addr;

    qb_wr_pipe #(
        .DATA_W       (DATA_W),
        .BYTES        (BYTES),
        .WR_LAG_TICKS (WR_LAG_TICKS)
    ) wpipe_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (wr_acc),
        .data_i   (wr_data_i),
        .be_i     (wr_be_i),
        .dev_d_o  (dev_d_o),
        .dev_be_o (dev_be_o)
    );

    qb_rd_ret #(
        .DATA_W       (DATA_W),
        .RD_LAT_TICKS (RD_LAT_TICKS)
    ) rret_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .issue_i     (dev_rd_o),
        .dev_q_i     (dev_q_i),
        .rsp_valid_o (rsp_valid_o),
        .rsp_data_o  (rsp_data_o)
    );
endmodule

// File: rtl/qb_burst_ctrl_chk.sv
module qb_burst_ctrl_chk
    import qb_pkg::*;
#(
    parameter int DATA_W = 18,
    parameter int BYTES  = 2,
    parameter int ADDR_W = 8
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       rd_valid_i,
    input logic                       rd_ready_o,
    input logic [ADDR_W-1:0]          rd_addr_i,
    input logic                       wr_valid_i,
    input logic                       wr_ready_o,
    input logic [ADDR_W-1:0]          wr_addr_i,
    input logic [QB_BURST*DATA_W-1:0] wr_data_i,
    input logic [QB_BURST*BYTES-1:0]  wr_be_i,
    input logic                       rsp_valid_o,
    input logic [DATA_W-1:0]          rsp_data_o,
    input logic                       dev_k_o,
    input logic                       dev_rd_o,
    input logic                       dev_wr_o,
    input logic [ADDR_W-1:0]          dev_addr_o,
    input logic [BYTES-1:0]           dev_be_o,
    input logic [DATA_W-1:0]          dev_d_o,
    input logic [DATA_W-1:0]          dev_q_i
);
    localparam int LAST = QB_BURST - 1;

    assert_ready_slot_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ready_o || wr_ready_o) |-> !dev_k_o);

    assert_cmd_on_k_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_rd_o || dev_wr_o) |-> dev_k_o);

    assert_one_cmd_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(dev_rd_o && dev_wr_o));

    assert_rd_issue_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid_i && rd_ready_o) |=> (dev_rd_o && dev_addr_o == $past(rd_addr_i)));

    assert_wr_issue_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid_i && wr_ready_o) |=> (dev_wr_o && dev_addr_o == $past(wr_addr_i)));

    assert_rd_spacing_R5: assert property (@(posedge clk) disable iff (!rst_n)
        dev_rd_o |-> ##2 !dev_rd_o);

    assert_wr_spacing_R5: assert property (@(posedge clk) disable iff (!rst_n)
        dev_wr_o |-> ##2 !dev_wr_o);

    assert_wr_first_beat_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid_i && wr_ready_o) |-> ##3
            (dev_d_o == $past(wr_data_i[DATA_W-1:0], 3) &&
             dev_be_o == $past(wr_be_i[BYTES-1:0], 3)));

    assert_wr_last_beat_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid_i && wr_ready_o) |-> ##6
            (dev_d_o == $past(wr_data_i[LAST*DATA_W +: DATA_W], 6) &&
             dev_be_o == $past(wr_be_i[LAST*BYTES +: BYTES], 6)));

    assert_rsp_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
        dev_rd_o |-> ##6 rsp_valid_o);

    assert_rsp_data_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid_o |-> (rsp_data_o == $past(dev_q_i)));
endmodule

bind qb_burst_ctrl qb_burst_ctrl_chk #(
    .DATA_W (DATA_W),
    .BYTES  (BYTES),
    .ADDR_W (ADDR_W)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .rd_valid_i  (rd_valid_i),
    .rd_ready_o  (rd_ready_o),
    .rd_addr_i   (rd_addr_i),
    .wr_valid_i  (wr_valid_i),
    .wr_ready_o  (wr_ready_o),
    .wr_addr_i   (wr_addr_i),
    .wr_data_i   (wr_data_i),
    .wr_be_i     (wr_be_i),
    .rsp_valid_o (rsp_valid_o),
    .rsp_data_o  (rsp_data_o),
    .dev_k_o     (dev_k_o),
    .dev_rd_o    (dev_rd_o),
    .dev_wr_o    (dev_wr_o),
    .dev_addr_o  (dev_addr_o),
    .dev_be_o    (dev_be_o),
    .dev_d_o     (dev_d_o),
    .dev_q_i     (dev_q_i)
);

// File: tb/qb_burst_ctrl_tb_top.sv
module qb_burst_ctrl_tb_top;
    localparam int TCK  = 10;
    localparam int DW   = 18;
    localparam int BY   = 2;
    localparam int AW   = 8;
    localparam int BU   = 4;
    localparam int LANE = DW / BY;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              rd_valid = 1'b0, wr_valid = 1'b0;
    logic              rd_ready_o, wr_ready_o;
    logic [AW-1:0]     rd_addr = '0, wr_addr = '0;
    logic [BU*DW-1:0]  wr_data = '0;
    logic [BU*BY-1:0]  wr_be = '0;
    logic              rsp_valid_o;
    logic [DW-1:0]     rsp_data_o;
    logic              dev_k_o, dev_rd_o, dev_wr_o;
    logic [AW-1:0]     dev_addr_o;
    logic [BY-1:0]     dev_be_o;
    logic [DW-1:0]     dev_d_o;
    logic [DW-1:0]     dev_q = '0;

    qb_burst_ctrl #(.DATA_W(DW), .BYTES(BY), .ADDR_W(AW)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .rd_valid_i(rd_valid), .rd_ready_o(rd_ready_o), .rd_addr_i(rd_addr),
        .wr_valid_i(wr_valid), .wr_ready_o(wr_ready_o), .wr_addr_i(wr_addr),
        .wr_data_i(wr_data), .wr_be_i(wr_be),
        .rsp_valid_o(rsp_valid_o), .rsp_data_o(rsp_data_o),
        .dev_k_o(dev_k_o), .dev_rd_o(dev_rd_o), .dev_wr_o(dev_wr_o),
        .dev_addr_o(dev_addr_o), .dev_be_o(dev_be_o), .dev_d_o(dev_d_o),
        .dev_q_i(dev_q)
    );

    always #(TCK/2) clk = ~clk;

    int checks = 0;
    int errors = 0;
    int n = 100;
    int last_rd_acc = -100, last_wr_acc = -100;
    int first_kind = 0;
    int overlap = 0;
    int rnd_on = 0, rate = 4;

    // expectation rings indexed by tick modulo 16
    int            cx_v [16];
    logic [AW-1:0] cx_a [16];
    logic          wx_v [16];
    logic [DW-1:0] wx_d [16];
    logic [BY-1:0] wx_be[16];
    logic          rx_v [16];
    logic [DW-1:0] rx_d [16];

    // reference memory (updated at accept) and device model memory
    logic [DW-1:0] refm [256][BU];
    logic [DW-1:0] dmem [256][BU];
    logic          h_rd [16], h_wr [16];
    logic [AW-1:0] h_ra [16], h_wa [16];
    logic [DW-1:0] stg_d [BU];
    logic [BY-1:0] stg_be[BU];

    // staged next inputs
    logic             nx_rv = 1'b0, nx_wv = 1'b0, nx_rst = 1'b0;
    logic [AW-1:0]    nx_ra = '0, nx_wa = '0;
    logic [BU*DW-1:0] nx_wd = '0;
    logic [BU*BY-1:0] nx_be = '0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s tick %0d: got %h expected %h", req, n, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] merge(input logic [DW-1:0] old_w, input logic [DW-1:0] new_w,
                                            input logic [BY-1:0] en);
        logic [DW-1:0] r = old_w;
        for (int j = 0; j < BY; j++)
            if (en[j]) r[j*LANE +: LANE] = new_w[j*LANE +: LANE];
        return r;
    endfunction

    task automatic observe();
        int s = n % 16;
        if (rst_n) begin
            if (dev_k_o) chk("R1", {30'd0, rd_ready_o, wr_ready_o}, 32'd0);
            chk("R3", {31'd0, dev_rd_o}, {31'd0, cx_v[s] == 1});
            chk("R4", {31'd0, dev_wr_o}, {31'd0, cx_v[s] == 2});
            if (cx_v[s] != 0) chk("R3 R4 address", {24'd0, dev_addr_o}, {24'd0, cx_a[s]});
            if (dev_rd_o || dev_wr_o) chk("R2", {31'd0, dev_k_o}, 32'd1);
            chk("R7", {30'd0, dev_be_o}, wx_v[s] ? {30'd0, wx_be[s]} : 32'd0);
            if (wx_v[s]) chk("R7", {14'd0, dev_d_o}, {14'd0, wx_d[s]});
            chk("R8", {31'd0, rsp_valid_o}, {31'd0, rx_v[s]});
            if (rx_v[s]) chk("R8", {14'd0, rsp_data_o}, {14'd0, rx_d[s]});
            if (!dev_k_o && last_rd_acc == n - 2) chk("R5", {31'd0, rd_ready_o}, 32'd0);
            if (!dev_k_o && last_wr_acc == n - 2) chk("R5", {31'd0, wr_ready_o}, 32'd0);
            if (rsp_valid_o && dev_be_o != '0) overlap++;
        end
        cx_v[s] = 0; wx_v[s] = 1'b0; rx_v[s] = 1'b0;
    endtask

    // behavioural device: reads served before writes commit in a tick
    task automatic device();
        int s = n % 16;
        h_rd[s] = dev_rd_o; h_ra[s] = dev_addr_o;
        h_wr[s] = dev_wr_o; h_wa[s] = dev_addr_o;
        dev_q = DW'($urandom);
        for (int k = 0; k < BU; k++) begin
            int p = (n - 5 - k) % 16;
            if (h_rd[p]) dev_q = dmem[h_ra[p]][k];
        end
        begin
            int c = (n - 6) % 16;
            if (h_wr[c])
                for (int k = 0; k < BU; k++)
                    dmem[h_wa[c]][k] = merge(dmem[h_wa[c]][k], stg_d[k], stg_be[k]);
        end
        for (int k = 0; k < BU; k++) begin
            int p = (n - 2 - k) % 16;
            if (h_wr[p]) begin stg_d[k] = dev_d_o; stg_be[k] = dev_be_o; end
        end
    endtask

    task automatic gen();
        if (!nx_rv && ($urandom % rate) == 0) begin
            nx_rv = 1'b1; nx_ra = AW'($urandom % 8);
        end
        if (!nx_wv && ($urandom % rate) == 0) begin
            nx_wv = 1'b1; nx_wa = AW'($urandom % 8);
            for (int k = 0; k < BU; k++) nx_wd[k*DW +: DW] = DW'($urandom);
            nx_be = (BU*BY)'($urandom);
        end
    endtask

    task automatic record();
        logic acc_r, acc_w;
        if (!rst_n) return;
        acc_r = rd_valid && rd_ready_o;
        acc_w = wr_valid && wr_ready_o;
        if (acc_r) begin
            chk("R5", {31'd0, (n - last_rd_acc) >= 4}, 32'd1);
            cx_v[(n+1)%16] = 1; cx_a[(n+1)%16] = rd_addr;
            for (int k = 0; k < BU; k++) begin
                rx_v[(n+7+k)%16] = 1'b1;
                rx_d[(n+7+k)%16] = refm[rd_addr][k];
            end
            last_rd_acc = n; nx_rv = 1'b0;
            if (first_kind == 0) first_kind = 1;
        end
        if (acc_w) begin
            chk("R5", {31'd0, (n - last_wr_acc) >= 4}, 32'd1);
            cx_v[(n+1)%16] = 2; cx_a[(n+1)%16] = wr_addr;
            for (int k = 0; k < BU; k++) begin
                wx_v[(n+3+k)%16]  = 1'b1;
                wx_d[(n+3+k)%16]  = wr_data[k*DW +: DW];
                wx_be[(n+3+k)%16] = wr_be[k*BY +: BY];
                refm[wr_addr][k] = merge(refm[wr_addr][k], wr_data[k*DW +: DW], wr_be[k*BY +: BY]);
            end
            last_wr_acc = n; nx_wv = 1'b0;
            if (first_kind == 0) first_kind = 2;
        end
    endtask

    task automatic step();
        @(negedge clk);
        n++;
        observe();
        device();
        if (rnd_on != 0) gen();
        rst_n = nx_rst;
        rd_valid = nx_rv; rd_addr = nx_ra;
        wr_valid = nx_wv; wr_addr = nx_wa; wr_data = nx_wd; wr_be = nx_be;
        #1;
        record();
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        #(TCK * 150000);
        checks++; errors++;
        $display("FAIL watchdog (all requirements): got timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 16; i++) begin
            cx_v[i] = 0; cx_a[i] = '0; wx_v[i] = 1'b0; wx_d[i] = '0; wx_be[i] = '0;
            rx_v[i] = 1'b0; rx_d[i] = '0; h_rd[i] = 1'b0; h_wr[i] = 1'b0;
            h_ra[i] = '0; h_wa[i] = '0;
        end
        for (int a = 0; a < 256; a++)
            for (int k = 0; k < BU; k++) begin refm[a][k] = '0; dmem[a][k] = '0; end
        for (int k = 0; k < BU; k++) begin stg_d[k] = '0; stg_be[k] = '0; end

        // R1: outputs during and right after reset
        repeat (4) step();
        chk("R1", {29'd0, dev_rd_o, dev_wr_o, rsp_valid_o}, 32'd0);
        chk("R1", {30'd0, dev_be_o}, 32'd0);
        nx_rst = 1'b1;
        step();
        step();
        chk("R1", {29'd0, dev_rd_o, dev_wr_o, rsp_valid_o}, 32'd0);
        chk("R1", {30'd0, dev_be_o}, 32'd0);

        // R6: both ports eligible after reset, read wins
        nx_rv = 1'b1; nx_ra = 8'd3;
        nx_wv = 1'b1; nx_wa = 8'd3; nx_wd = {4{18'h2A5C3}}; nx_be = 8'hFF;
        first_kind = 0;
        while (first_kind == 0) step();
        chk("R6", first_kind, 32'd1);
        while (nx_wv) step();

        // R6: read served last, then both eligible -> write wins
        repeat (8) step();
        nx_rv = 1'b1; nx_ra = 8'd5;
        while (nx_rv) step();
        repeat (8) step();
        first_kind = 0;
        nx_rv = 1'b1; nx_ra = 8'd3;
        nx_wv = 1'b1; nx_wa = 8'd3; nx_wd = {18'h00011, 18'h3FFFF, 18'h15555, 18'h00100}; nx_be = 8'b0110_1001;
        while (first_kind == 0) step();
        chk("R6", first_kind, 32'd2);
        while (nx_rv || nx_wv) step();
        repeat (12) step();

        // R7 R9: saturated traffic gives back-to-back bursts on both ports
        rnd_on = 1; rate = 1;
        repeat (200) step();
        // mixed random traffic over a small address pool
        rate = 4;
        repeat (3000) step();
        rnd_on = 0;
        while (nx_rv || nx_wv) step();
        repeat (20) step();

        chk("R9", {31'd0, overlap > 0}, 32'd1);
        summary();
        $finish;
    end
endmodule